// File: doc/BRIEF.md
# Gated Microoperation Register Datapath

This block holds four general registers and a program counter, all of one parameterised width. On each clock it carries out at most one register-transfer microoperation. An operation code picks the operation. Two selectors name the source registers, a third names the destination, and a data input supplies values to load. The operation takes place only while its control expression is true. That expression is the OR of two control variables. When the expression is false, every register, the link bit and both status flags keep their values.

The operations fall into four groups:

- Transfer: copy a register, or load the data input.
- Arithmetic: add, and subtract under a mode bit, done as the first operand plus the inverted second operand plus one. Also reverse subtract, increment, decrement, and ones and twos complement.
- Bitwise logic: AND, OR, XOR.
- Shifts: one-bit left and right. They fill with zero, or in link mode they take the fill from a one-bit link register and catch the outgoing bit in it.

Zero and carry status flags report on the last operation that executed. A sequencer drives the block one microoperation per cycle and reads every register through a flat output bus.

Top module: `uop_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four registers, the program counter, the link bit and both flags.
- R2: An operation executes only when `ctl_k1 | ctl_k2` is 1 and `op` is in 0..12. Otherwise the registers, PC, link and flags keep their values. Either control variable alone is enough.
- R3: Selector codes 0..3 name R0..R3 and any code of 4 or above names the PC, for both sources and the destination. One register may be source and destination at once. Op 0 copies source A and op 1 loads `din`.
- R4: Op 2 writes A+B when `sub_mode`=0 and A+~B+1 when `sub_mode`=1, modulo 2^W. The carry flag takes the adder carry-out.
- R5: Op 3 writes B+~A+1 (B minus A) with its carry-out.
- R6: Op 4 writes A+1 and op 5 writes A plus all ones (A-1), each with its carry-out.
- R7: Op 6 writes ~A with carry 0. Op 7 writes ~A+1 with its carry-out.
- R8: Ops 8, 9 and 10 write A AND B, A OR B and A XOR B. For A=10101010 and B=11110000, NOT, OR, AND and XOR give 01010101, 11111010, 10100000 and 01011010.
- R9: With `link_mode`=0, op 11 shifts A left one place and op 12 shifts it right, both zero-filled, and the link bit is unchanged. 11001001 gives 10010010 (left) and 01100100 (right).
- R10: With `link_mode`=1, the vacated bit of a shift takes the old link bit, and the link bit takes the bit shifted out (A[W-1] for left, A[0] for right).
- R11: The carry flag is cleared by every executing op that is not arithmetic (ops 0, 1, 6, 8..12).
- R12: The zero flag is set to 1 exactly when the value written is all zeros. It changes only on cycles that execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_k1 | input | 1 | First control variable |
| ctl_k2 | input | 1 | Second control variable |
| sub_mode | input | 1 | Selects subtract for op 2 |
| link_mode | input | 1 | Shifts use the link bit |
| op | input | 4 | Operation code |
| sel_a | input | 3 | Source A selector |
| sel_b | input | 3 | Source B selector |
| sel_dst | input | 3 | Destination selector |
| din | input | W | Data for the load operation |
| regs_flat | output | 5*W | R0 in the low W bits, then R1..R3, PC in the top W bits |
| link_o | output | 1 | Link bit |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |

## Verification
The operations are first tried on chosen operands:

- The 10101010 and 11110000 pair separates the four logic operations from one another.
- The 11001001 pattern shows the shift direction and the fill bit.
- 0xFF for increment and 0x00 for decrement and twos complement show whether the carry-out and the wrap are right.
- Sources equal to the destination, selectors above 3 and each control variable alone show the selection and gating.

A long stream of pseudo-random operations is then checked every cycle against a behavioural model. This catches cross-effects between the flags, the link bit and later operations.

// File: rtl/uop_pkg.sv
package uop_pkg;
    typedef enum logic [3:0] {
        OP_MOVE = 4'd0,
        OP_LOAD = 4'd1,
        OP_ADDSUB = 4'd2,
        OP_RSUB = 4'd3,
        OP_INC = 4'd4,
        OP_DEC = 4'd5,
        OP_NOT = 4'd6,
        OP_NEG = 4'd7,
        OP_AND = 4'd8,
        OP_OR = 4'd9,
        OP_XOR = 4'd10,
        OP_SHL = 4'd11,
        OP_SHR = 4'd12
    } uop_op_e;

    localparam logic [3:0] OP_LAST = 4'd12;
endpackage

// File: rtl/uop_srcmux.sv
module uop_srcmux #(
    parameter int W = 8,
    parameter int NREG = 5,
    parameter int SEL_W = 3
) (
    input  logic [NREG-1:0][W-1:0] regs,
    input  logic [SEL_W-1:0]       sel,
    output logic [W-1:0]           data
);
    logic [NREG-1:0] hit;

    // one-hot hit per register; codes at or past the last index map to it
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        if (i == NREG - 1) begin : g_top
            assign hit[i] = (int'(sel) >= i);
        end else begin : g_low
            assign hit[i] = (int'(sel) == i);
        end
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) data = data | regs[i];
        end
    end
endmodule

// File: rtl/uop_alu.sv
module uop_alu
    import uop_pkg::*;
#(
    parameter int W = 8
) (
    input  uop_op_e      op,
    input  logic         sub_mode,
    input  logic         link_mode,
    input  logic         link_in,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] din,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         link_out,
    output logic         link_we
);
    logic [W-1:0] add_x, add_y;
    logic         add_cin;
    logic [W:0]   sum;
    logic         fill;

    // adder operand steering for every arithmetic operation
    always_comb begin
        add_x = a;
        add_y = '0;
        add_cin = 1'b0;
        unique case (op)
            OP_ADDSUB: begin
                add_y = sub_mode ? ~b : b;
                add_cin = sub_mode;
            end
            OP_RSUB: begin
                add_x = b;
                add_y = ~a;
                add_cin = 1'b1;
            end
            OP_INC: add_cin = 1'b1;
            OP_DEC: add_y = '1;
            OP_NEG: begin
                add_x = ~a;
                add_cin = 1'b1;
            end
            default: ;
        endcase
    end

    assign sum  = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
    assign fill = link_mode & link_in;

    always_comb begin
        res = a;
        carry = 1'b0;
        link_out = link_in;
        link_we = 1'b0;
        unique case (op)
            OP_MOVE: res = a;
            OP_LOAD: res = din;
            OP_ADDSUB, OP_RSUB, OP_INC, OP_DEC, OP_NEG: begin
                res = sum[W-1:0];
                carry = sum[W];
            end
            OP_NOT: res = ~a;
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHL: begin
                res = {a[W-2:0], fill};
                link_out = a[W-1];
                link_we = link_mode;
            end
            OP_SHR: begin
                res = {fill, a[W-1:1]};
                link_out = a[0];
                link_we = link_mode;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
    import uop_pkg::*;
#(
    parameter int W = 8,
    parameter int NGP = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctl_k1,
    input  logic                  ctl_k2,
    input  logic                  sub_mode,
    input  logic                  link_mode,
    input  logic [3:0]            op,
    input  logic [2:0]            sel_a,
    input  logic [2:0]            sel_b,
    input  logic [2:0]            sel_dst,
    input  logic [W-1:0]          din,
    output logic [(NGP+1)*W-1:0]  regs_flat,
    output logic                  link_o,
    output logic                  zero_o,
    output logic                  carry_o
);
    localparam int NREG = NGP + 1;
    localparam int SEL_W = 3;

    typedef struct packed {
        logic [NREG-1:0][W-1:0] regs;
        logic                   link;
        logic                   zero;
        logic                   carry;
    } dp_state_t;

    dp_state_t st_d, st_q;

    uop_op_e      op_e;
    logic         op_ok;
    logic         exec;
    logic [W-1:0] opnd_a, opnd_b, alu_res;
    logic         alu_carry, alu_link, alu_link_we;
    int           dst_idx;

    assign op_e  = uop_op_e'(op);
    assign op_ok = (op <= OP_LAST);
    assign exec  = (ctl_k1 | ctl_k2) & op_ok;
    assign dst_idx = (int'(sel_dst) >= NGP) ? NGP : int'(sel_dst);

    uop_srcmux #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) u_mux_a (
        .regs(st_q.regs), .sel(sel_a), .data(opnd_a)
    );
    uop_srcmux #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) u_mux_b (
        .regs(st_q.regs), .sel(sel_b), .data(opnd_b)
    );

    uop_alu #(.W(W)) u_alu (
        .op(op_e), .sub_mode(sub_mode), .link_mode(link_mode),
        .link_in(st_q.link), .a(opnd_a), .b(opnd_b), .din(din),
        .res(alu_res), .carry(alu_carry), .link_out(alu_link),
        .link_we(alu_link_we)
    );

    always_comb begin
        st_d = st_q;
        if (exec) begin
            st_d.regs[dst_idx] = alu_res;
            st_d.zero = (alu_res == '0);
            st_d.carry = alu_carry;
            if (alu_link_we) st_d.link = alu_link;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign regs_flat = st_q.regs;
    assign link_o = st_q.link;
    assign zero_o = st_q.zero;
    assign carry_o = st_q.carry;

    // R2
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !exec |=> $stable(st_q));

    // R12
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        exec |=> (zero_o == (st_q.regs[$past(dst_idx)] == '0)));

    // R11
    carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && !(op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd7})) |=> !carry_o);

    // R9
    link_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(exec && link_mode && (op inside {4'd11, 4'd12})) |=> $stable(link_o));

    // R4
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && op == 4'd2 && !sub_mode) |=>
            (st_q.regs[$past(dst_idx)] == W'($past(opnd_a) + $past(opnd_b))));
endmodule

// File: tb/test_uop_datapath.sv
module test_uop_datapath;
    localparam int W = 8;
    localparam int NR = 5;
    localparam int M = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic k1 = 1'b0, k2 = 1'b0, smode = 1'b0, lmode = 1'b0;
    logic [3:0] op = 4'd0;
    logic [2:0] sa = 3'd0, sb = 3'd0, sd = 3'd0;
    logic [W-1:0] din = '0;
    logic [NR*W-1:0] regs_flat;
    logic link_o, zero_o, carry_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int m_reg [NR];
    int m_link, m_zero, m_carry;
    int seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    uop_datapath #(.W(W), .NGP(4)) i_uop_datapath (
        .clk(clk), .rst(rst), .ctl_k1(k1), .ctl_k2(k2), .sub_mode(smode),
        .link_mode(lmode), .op(op), .sel_a(sa), .sel_b(sb), .sel_dst(sd),
        .din(din), .regs_flat(regs_flat), .link_o(link_o), .zero_o(zero_o),
        .carry_o(carry_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < NR; i++)
            chk(tag, $sformatf("reg%0d", i), int'(regs_flat[i*W +: W]), m_reg[i]);
        chk(tag, "link", int'(link_o), m_link);
        chk(tag, "zero", int'(zero_o), m_zero);
        chk(tag, "carry", int'(carry_o), m_carry);
    endtask

    function automatic int pick(input int s);
        return (s >= 4) ? m_reg[4] : m_reg[s];
    endfunction

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        for (int i = 0; i < NR; i++) m_reg[i] = 0;
        m_link = 0; m_zero = 0; m_carry = 0;
        compare(tag);
    endtask

    task automatic step(input string tag, input int c1, input int c2, input int x,
                        input int lm, input int opc, input int a, input int b,
                        input int d, input int dv);
        int av, bv, r, c, s, fill, nl, ex;
        @(negedge clk);
        k1 = c1[0]; k2 = c2[0]; smode = x[0]; lmode = lm[0];
        op = opc[3:0]; sa = a[2:0]; sb = b[2:0]; sd = d[2:0]; din = dv[W-1:0];
        av = pick(a); bv = pick(b);
        r = 0; c = 0; nl = m_link;
        fill = lm ? m_link : 0;
        case (opc)
            0: r = av;
            1: r = dv & M;
            2: begin s = av + (x ? (~bv & M) : bv) + x; r = s & M; c = (s >> W) & 1; end
            3: begin s = bv + (~av & M) + 1; r = s & M; c = (s >> W) & 1; end
            4: begin s = av + 1; r = s & M; c = (s >> W) & 1; end
            5: begin s = av + M; r = s & M; c = (s >> W) & 1; end
            6: r = ~av & M;
            7: begin s = (~av & M) + 1; r = s & M; c = (s >> W) & 1; end
            8: r = av & bv;
            9: r = av | bv;
            10: r = av ^ bv;
            11: begin r = ((av << 1) & M) | fill; if (lm) nl = (av >> (W-1)) & 1; end
            12: begin r = (av >> 1) | (fill << (W-1)); if (lm) nl = av & 1; end
            default: ;
        endcase
        ex = ((c1 | c2) != 0) && (opc <= 12);
        @(posedge clk);
        #1;
        if (ex) begin
            m_reg[(d >= 4) ? 4 : d] = r;
            m_zero = (r == 0);
            m_carry = c;
            m_link = nl;
        end
        compare(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset("R1");
        // R3: loads into every register and the PC (code 7 maps to PC)
        step("R3", 1,0,0,0, 1, 0,0, 0, 8'h11);
        step("R3", 1,0,0,0, 1, 0,0, 1, 8'hAA);
        step("R3", 1,0,0,0, 1, 0,0, 2, 8'hF0);
        step("R3", 1,0,0,0, 1, 0,0, 3, 8'hC9);
        step("R3", 1,0,0,0, 1, 0,0, 7, 8'h40);
        step("R3", 1,0,0,0, 0, 4,0, 0, 0);   // R0 <- PC
        step("R3", 1,0,0,0, 0, 1,0, 4, 0);   // PC <- R1
        // R8: logic example values
        step("R8", 1,0,0,0, 6, 1,0, 0, 0);
        step("R8", 1,0,0,0, 9, 1,2, 0, 0);
        step("R8", 1,0,0,0, 8, 1,2, 0, 0);
        step("R8", 1,0,0,0, 10, 1,2, 0, 0);
        step("R8", 1,0,0,0, 10, 1,1, 0, 0);   // R12: zero result
        // R2: OR condition from k2 alone, and inhibited cases
        step("R2", 0,1,0,0, 9, 1,3, 0, 0);
        step("R2", 0,0,0,1, 11, 3,0, 3, 0);
        step("R2", 1,1,0,0, 13, 1,2, 1, 0);
        step("R2", 0,0,1,0, 2, 1,2, 1, 0);
        // R9: zero-filled shifts
        step("R9", 1,0,0,0, 11, 3,0, 0, 0);
        step("R9", 1,0,0,0, 12, 3,0, 0, 0);
        // R4: add, subtract, same register as source and destination
        step("R4", 1,0,0,0, 2, 1,2, 1, 0);
        step("R4", 1,0,1,0, 2, 1,2, 0, 0);
        step("R4", 1,0,1,0, 2, 2,2, 2, 0);
        // R5
        step("R5", 1,0,0,0, 1, 0,0, 1, 8'h05);
        step("R5", 1,0,0,0, 1, 0,0, 2, 8'h03);
        step("R5", 1,0,0,0, 3, 1,2, 3, 0);
        step("R5", 1,0,0,0, 3, 2,1, 3, 0);
        // R6: increment at all-ones and decrement at zero
        step("R6", 1,0,0,0, 1, 0,0, 0, 8'hFF);
        step("R6", 1,0,0,0, 4, 0,0, 0, 0);
        step("R6", 1,0,0,0, 5, 0,0, 0, 0);
        step("R6", 1,0,0,0, 5, 1,0, 1, 0);
        // R7
        step("R7", 1,0,0,0, 1, 0,0, 0, 8'h00);
        step("R7", 1,0,0,0, 7, 0,0, 1, 0);
        step("R7", 1,0,0,0, 7, 2,0, 2, 0);
        step("R7", 1,0,0,0, 6, 2,0, 2, 0);
        // R11: carry then a transfer clears it
        step("R11", 1,0,0,0, 4, 0,0, 0, 0);
        step("R11", 1,0,0,0, 1, 0,0, 3, 8'hFF);
        step("R11", 1,0,0,0, 4, 3,0, 3, 0);
        step("R11", 1,0,0,0, 0, 1,0, 2, 0);
        // R10: link mode shifts
        step("R10", 1,0,0,0, 1, 0,0, 3, 8'hC9);
        step("R10", 1,0,0,1, 11, 3,0, 3, 0);
        step("R10", 1,0,0,1, 11, 3,0, 3, 0);
        step("R10", 1,0,0,1, 12, 3,0, 3, 0);
        step("R10", 1,0,0,1, 12, 3,0, 3, 0);
        step("R10", 0,1,0,1, 12, 3,0, 4, 0);
        // R12: zero flag held while inhibited
        step("R12", 1,0,0,0, 1, 0,0, 0, 0);
        step("R12", 0,0,0,0, 1, 0,0, 0, 8'h7);
        // mixed stream
        for (int i = 0; i < 400; i++) begin
            int v;
            seed = seed * 1103515245 + 12345;
            v = (seed >>> 8);
            step("R13", v & 1, (v >> 1) & 1 & ((v >> 17) & 1), (v >> 2) & 1,
                 (v >> 3) & 1, (v >> 4) % 15, (v >> 8) & 7, (v >> 11) & 7,
                 (v >> 14) & 7, (v >> 18) & M);
        end
        // R1: reset after activity
        do_reset("R1");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule